// File: doc/BRIEF.md
# Four-State Programmable Logic Cell

This block is one tile of a fine-grained programmable fabric. Each of its four neighbours (north, east, south, west) sends it one A signal and one B signal. The cell sends back a single A output and a single B output, which every neighbour sees. Two input selectors pick one A source and one B source, and either selector may pick a constant 1. The chosen A signal is ANDed with a value read from one of four local buses, or with 1 when no bus is read. The chosen B signal is ANDed with a gate bit. A two-bit state code then fixes how these two AND results reach the outputs: passed straight through, swapped, combined into XOR/NAND, or combined into an XOR that a register captures, with the AND of the two results on B.

The cell can also act on its local buses. The four buses are two vertical and two horizontal, and each is modelled as a value that arrives plus a drive-value/drive-enable pair that leaves. The cell can drive its A output onto one bus, either always or only while the chosen B signal is high. It can also turn a signal between the first vertical and first horizontal bus, or between the second pair, in either direction. Each bus may take part in only one operation at a time: a read, a write or a turn. If the configuration breaks this rule, the cell raises a flag and drives nothing onto the offending bus.

The register takes its clock and an active-low asynchronous clear from column-level inputs.

Top module: `logic_cell4`

## Requirements
- R1: `cfg_a_src` values 0..3 select `nbr_a[0..3]` (0 north, 1 east, 2 south, 3 west) as the A operand. Values 4..7 select constant 1.
- R2: `cfg_b_src` selects the B operand from `nbr_b` with the same coding as R1. The right AND result is the B operand ANDed with `cfg_b_gate`.
- R3: The left AND result is the A operand ANDed with the read value. `cfg_rd_src` values 1..4 read `bus_val[0..3]` (bit 0 first vertical, 1 first horizontal, 2 second vertical, 3 second horizontal). Values 0, 5, 6 and 7 give a read value of 1.
- R4: When `cfg_state` = 0, `a_out` is the left AND result and `b_out` is the right AND result.
- R5: When `cfg_state` = 1, `a_out` is the right AND result and `b_out` is the left AND result.
- R6: When `cfg_state` = 2, `a_out` is the XOR of the two AND results and `b_out` is their NAND.
- R7: When `cfg_state` = 3, `a_out` shows a register that captures the XOR of the two AND results on every rising edge of `clk`, and `b_out` is the AND of the two AND results.
- R8: While `rst_n` is low the register is cleared at once, without waiting for a clock edge, and it stays cleared.
- R9: `cfg_wr_dst` values 1..4 drive `a_out` onto bus 0..3. The drive is always on when `cfg_wr_dyn` = 0, and only while the B operand is 1 when `cfg_wr_dyn` = 1. A bus that is not driven shows enable 0 and value 0.
- R10: `cfg_turn_en[p]` connects bus 2p with bus 2p+1. With `cfg_turn_dir[p]` = 0 the vertical bus value drives the horizontal bus. With `cfg_turn_dir[p]` = 1 the horizontal bus value drives the vertical bus.
- R11: A bus that is used by more than one of read, write and turn raises `cfg_illegal`, and its drive enable and drive value are both 0. All other buses behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock for the cell register |
| rst_n | input | 1 | Column reset, active low, asynchronous clear |
| nbr_a | input | 4 | A signals from N, E, S, W neighbours |
| nbr_b | input | 4 | B signals from N, E, S, W neighbours |
| cfg_a_src | input | 3 | A operand selector |
| cfg_b_src | input | 3 | B operand selector |
| cfg_b_gate | input | 1 | Gate bit ANDed with the B operand |
| cfg_rd_src | input | 3 | Local bus read selector |
| cfg_state | input | 2 | Function state 0..3 |
| cfg_wr_dst | input | 3 | Local bus write target |
| cfg_wr_dyn | input | 1 | Write enable follows the B operand when 1 |
| cfg_turn_en | input | 2 | Turn enable per vertical/horizontal pair |
| cfg_turn_dir | input | 2 | Turn direction per pair |
| bus_val | input | 4 | Present value of each local bus |
| a_out | output | 1 | A output to all neighbours |
| b_out | output | 1 | B output to all neighbours |
| bus_drv_val | output | 4 | Value the cell drives per bus |
| bus_drv_en | output | 4 | Drive enable per bus |
| cfg_illegal | output | 1 | Some bus is used by more than one operation |

## Verification
The bench builds the cell with the package defaults: four neighbours, four buses and therefore two turn pairs. With these values every selector code can be swept, including the codes that fall back to constant 1. Every pairing of read, write and turn on the same bus can also be forced. The register is checked both at clock edges and in the middle of a cycle, while reset is applied asynchronously.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
// Shared constants, the function-state type and a bus-code decoder for the logic cell.
package lc_pkg;
    localparam int unsigned NBR_CNT  = 4;
    localparam int unsigned BUS_CNT  = 4;
    localparam int unsigned SRC_W    = 3;
    localparam int unsigned PAIR_CNT = BUS_CNT / 2;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_XNAND = 2'd2,
        ST_REGXA = 2'd3
    } cell_state_e;

    // Maps code 1..BUS_CNT to a one-hot bus mask; any other code gives zero.
    function automatic logic [BUS_CNT-1:0] bus_onehot(input logic [SRC_W-1:0] code);
        logic [BUS_CNT-1:0] m;
        for (int i = 0; i < int'(BUS_CNT); i++) begin
            m[i] = (code == SRC_W'(i + 1));
        end
        return m;
    endfunction
endpackage

// File: rtl/lc_input_sel.sv
`timescale 1ns/1ps
// Operand selection: picks the A and B operands from the neighbours or constant 1,
// and picks the local-bus read value. Assumes codes at or above NBR_CNT mean
// constant 1, and a read code outside 1..BUS_CNT means "no read" (value 1).
module lc_input_sel
    import lc_pkg::*;
(
    input  logic [NBR_CNT-1:0] a_nbr,
    input  logic [NBR_CNT-1:0] b_nbr,
    input  logic [SRC_W-1:0]   a_src,
    input  logic [SRC_W-1:0]   b_src,
    input  logic [SRC_W-1:0]   rd_src,
    input  logic [BUS_CNT-1:0] bus_val,
    output logic               a_pick,
    output logic               b_pick,
    output logic               rd_pick,
    output logic [BUS_CNT-1:0] rd_hot
);
    // Neighbour multiplexers with a constant-1 fallback.
    always_comb begin
        a_pick = 1'b1;
        b_pick = 1'b1;
        for (int i = 0; i < int'(NBR_CNT); i++) begin
            if (a_src == SRC_W'(i)) a_pick = a_nbr[i];
            if (b_src == SRC_W'(i)) b_pick = b_nbr[i];
        end
    end

    // Local-bus read multiplexer; no selected bus reads as 1.
    always_comb begin
        rd_hot  = bus_onehot(rd_src);
        rd_pick = (rd_hot == '0) ? 1'b1 : |(rd_hot & bus_val);
    end
endmodule

// File: rtl/lc_fn_core.sv
`timescale 1ns/1ps
// Function core: the two upstream AND gates, the XOR register and the tandem
// output multiplexers. The register loads the XOR on every rising edge and is
// cleared asynchronously by the active-low column reset.
module lc_fn_core
    import lc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_pick,
    input  logic        b_pick,
    input  logic        rd_pick,
    input  logic        b_gate,
    input  cell_state_e state,
    output logic        a_out,
    output logic        b_out
);
    logic left_and;
    logic right_and;
    logic xor_q;

    // Upstream AND gates.
    always_comb begin
        left_and  = a_pick & rd_pick;
        right_and = b_pick & b_gate;
    end

    // XOR register with asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xor_q <= 1'b0;
        else        xor_q <= left_and ^ right_and;
    end

    // Output multiplexers switched together by the state code.
    always_comb begin
        unique case (state)
            ST_PASS:  begin a_out = left_and;             b_out = right_and;               end
            ST_SWAP:  begin a_out = right_and;            b_out = left_and;                end
            ST_XNAND: begin a_out = left_and ^ right_and; b_out = ~(left_and & right_and); end
            default:  begin a_out = xor_q;                b_out = left_and & right_and;    end
        endcase
    end

    // R7: the register holds the XOR seen at the previous edge.
    p_reg_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> xor_q == $past(left_and ^ right_and));

    // R6: in XOR/NAND state a high XOR implies a high NAND.
    p_xnand_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XNAND) |-> (b_out || !a_out));

    // R8: during reset the register reads zero at every edge.
    always @(posedge clk) begin
        if (!rst_n) p_reset_clear_r8: assert (xor_q == 1'b0);
    end
endmodule

// File: rtl/lc_bus_ctrl.sv
`timescale 1ns/1ps
// Local-bus control: write drive (static or gated by the B operand), turns
// between a vertical and a horizontal bus, and the one-operation-per-bus rule.
// Assumes bus 2p is vertical and bus 2p+1 horizontal in pair p.
module lc_bus_ctrl
    import lc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_CNT-1:0]  rd_hot,
    input  logic [SRC_W-1:0]    wr_dst,
    input  logic                wr_dyn,
    input  logic                b_pick,
    input  logic                a_out,
    input  logic [PAIR_CNT-1:0] turn_en,
    input  logic [PAIR_CNT-1:0] turn_dir,
    input  logic [BUS_CNT-1:0]  bus_val,
    output logic [BUS_CNT-1:0]  drv_val,
    output logic [BUS_CNT-1:0]  drv_en,
    output logic                illegal
);
    logic [BUS_CNT-1:0] wr_hot;
    logic [BUS_CNT-1:0] turn_use;
    logic [BUS_CNT-1:0] turn_drv;
    logic [BUS_CNT-1:0] turn_val;
    logic [BUS_CNT-1:0] clash;
    logic               wr_on;

    // Write target decode and dynamic gate.
    always_comb begin
        wr_hot = bus_onehot(wr_dst);
        wr_on  = wr_dyn ? b_pick : 1'b1;
    end

    // Turn connections, one per vertical/horizontal pair.
    for (genvar p = 0; p < int'(PAIR_CNT); p++) begin : g_pair
        always_comb begin
            turn_use[2*p]   = turn_en[p];
            turn_use[2*p+1] = turn_en[p];
            turn_drv[2*p]   = turn_en[p] &  turn_dir[p];
            turn_drv[2*p+1] = turn_en[p] & ~turn_dir[p];
            turn_val[2*p]   = bus_val[2*p+1];
            turn_val[2*p+1] = bus_val[2*p];
        end

        // R10: a turn never drives both buses of its pair.
        p_turn_one_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
            turn_en[p] |-> !(drv_en[2*p] && drv_en[2*p+1]));
    end

    // Per-bus usage check and drive resolution.
    for (genvar i = 0; i < int'(BUS_CNT); i++) begin : g_bus
        always_comb begin
            clash[i]   = (rd_hot[i] & wr_hot[i]) | (rd_hot[i] & turn_use[i]) | (wr_hot[i] & turn_use[i]);
            drv_en[i]  = ~clash[i] & ((wr_hot[i] & wr_on) | turn_drv[i]);
            drv_val[i] = drv_en[i] & (wr_hot[i] ? a_out : turn_val[i]);
        end
    end

    // Flag any rule break.
    always_comb illegal = |clash;

    // R9: a gated write with B low and no turn drives no bus.
    p_dyn_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dyn && !b_pick && turn_en == '0) |-> (drv_en == '0));

    // R11: a read/write collision is flagged and that bus stays undriven.
    p_clash_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hot & wr_hot) != '0) |-> (illegal && ((rd_hot & wr_hot & drv_en) == '0)));
endmodule

// File: rtl/logic_cell4.sv
`timescale 1ns/1ps
// Top of the four-state programmable logic cell. Wires operand selection, the
// function core and the local-bus control. Configuration inputs are assumed
// static for as long as a function is in use; clk and rst_n come from the column.
module logic_cell4
    import lc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBR_CNT-1:0]  nbr_a,
    input  logic [NBR_CNT-1:0]  nbr_b,
    input  logic [SRC_W-1:0]    cfg_a_src,
    input  logic [SRC_W-1:0]    cfg_b_src,
    input  logic                cfg_b_gate,
    input  logic [SRC_W-1:0]    cfg_rd_src,
    input  logic [1:0]          cfg_state,
    input  logic [SRC_W-1:0]    cfg_wr_dst,
    input  logic                cfg_wr_dyn,
    input  logic [PAIR_CNT-1:0] cfg_turn_en,
    input  logic [PAIR_CNT-1:0] cfg_turn_dir,
    input  logic [BUS_CNT-1:0]  bus_val,
    output logic                a_out,
    output logic                b_out,
    output logic [BUS_CNT-1:0]  bus_drv_val,
    output logic [BUS_CNT-1:0]  bus_drv_en,
    output logic                cfg_illegal
);
    logic               a_pick;
    logic               b_pick;
    logic               rd_pick;
    logic [BUS_CNT-1:0] rd_hot;
    cell_state_e        state;

    // State code cast to the enumerated type.
    always_comb state = cell_state_e'(cfg_state);

    lc_input_sel u_sel (
        .a_nbr   (nbr_a),
        .b_nbr   (nbr_b),
        .a_src   (cfg_a_src),
        .b_src   (cfg_b_src),
        .rd_src  (cfg_rd_src),
        .bus_val (bus_val),
        .a_pick  (a_pick),
        .b_pick  (b_pick),
        .rd_pick (rd_pick),
        .rd_hot  (rd_hot)
    );

    lc_fn_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_pick  (a_pick),
        .b_pick  (b_pick),
        .rd_pick (rd_pick),
        .b_gate  (cfg_b_gate),
        .state   (state),
        .a_out   (a_out),
        .b_out   (b_out)
    );

    lc_bus_ctrl u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hot   (rd_hot),
        .wr_dst   (cfg_wr_dst),
        .wr_dyn   (cfg_wr_dyn),
        .b_pick   (b_pick),
        .a_out    (a_out),
        .turn_en  (cfg_turn_en),
        .turn_dir (cfg_turn_dir),
        .bus_val  (bus_val),
        .drv_val  (bus_drv_val),
        .drv_en   (bus_drv_en),
        .illegal  (cfg_illegal)
    );
endmodule

// File: tb/logic_cell4_test.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference model evaluated every cycle.
module logic_cell4_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nbr_a = '0, nbr_b = '0, bus_val = '0;
    logic [2:0] cfg_a_src = '0, cfg_b_src = '0, cfg_rd_src = '0, cfg_wr_dst = '0;
    logic       cfg_b_gate = 1'b0, cfg_wr_dyn = 1'b0;
    logic [1:0] cfg_state = 2'd3, cfg_turn_en = '0, cfg_turn_dir = '0;
    logic       a_out, b_out, cfg_illegal;
    logic [3:0] bus_drv_val, bus_drv_en;

    int checks = 0;
    int errors = 0;
    int ref_q  = 0;
    int ex_a, ex_b, ex_x, ex_ill;
    int ex_en [4];
    int ex_val[4];

    always #4 clk = ~clk;

    logic_cell4 uut (
        .clk(clk), .rst_n(rst_n), .nbr_a(nbr_a), .nbr_b(nbr_b),
        .cfg_a_src(cfg_a_src), .cfg_b_src(cfg_b_src), .cfg_b_gate(cfg_b_gate),
        .cfg_rd_src(cfg_rd_src), .cfg_state(cfg_state), .cfg_wr_dst(cfg_wr_dst),
        .cfg_wr_dyn(cfg_wr_dyn), .cfg_turn_en(cfg_turn_en), .cfg_turn_dir(cfg_turn_dir),
        .bus_val(bus_val), .a_out(a_out), .b_out(b_out), .bus_drv_val(bus_drv_val),
        .bus_drv_en(bus_drv_en), .cfg_illegal(cfg_illegal)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic model();
        int a, b, rv, l, r, rdb, wrb, dst;
        a  = (cfg_a_src < 4) ? int'(nbr_a[cfg_a_src[1:0]]) : 1;
        b  = (cfg_b_src < 4) ? int'(nbr_b[cfg_b_src[1:0]]) : 1;
        rdb = (cfg_rd_src >= 1 && cfg_rd_src <= 4) ? int'(cfg_rd_src) - 1 : -1;
        wrb = (cfg_wr_dst >= 1 && cfg_wr_dst <= 4) ? int'(cfg_wr_dst) - 1 : -1;
        rv = (rdb >= 0) ? int'(bus_val[rdb]) : 1;
        l  = a & rv;
        r  = b & int'(cfg_b_gate);
        ex_x = l ^ r;
        case (cfg_state)
            2'd0:    begin ex_a = l;     ex_b = r; end
            2'd1:    begin ex_a = r;     ex_b = l; end
            2'd2:    begin ex_a = ex_x;  ex_b = (l & r) ? 0 : 1; end
            default: begin ex_a = ref_q; ex_b = l & r; end
        endcase
        ex_ill = 0;
        for (int i = 0; i < 4; i++) begin
            int uses, tu;
            tu   = int'(cfg_turn_en[i/2]);
            uses = (rdb == i ? 1 : 0) + (wrb == i ? 1 : 0) + tu;
            ex_en[i] = 0; ex_val[i] = 0;
            dst = (i % 2 == 0) ? int'(cfg_turn_dir[i/2]) : 1 - int'(cfg_turn_dir[i/2]);
            if (wrb == i && (cfg_wr_dyn == 1'b0 || b == 1)) begin
                ex_en[i] = 1; ex_val[i] = ex_a;
            end else if (tu == 1 && dst == 1) begin
                ex_en[i] = 1; ex_val[i] = int'(bus_val[i ^ 1]);
            end
            if (uses > 1) begin
                ex_ill = 1; ex_en[i] = 0; ex_val[i] = 0;
            end
        end
    endtask

    // Inputs were applied just after a negedge: compare, then track the register.
    task automatic run(input string tag);
        #3;
        model();
        chk(tag, "a_out", int'(a_out), ex_a);
        chk(tag, "b_out", int'(b_out), ex_b);
        chk(tag, "illegal", int'(cfg_illegal), ex_ill);
        for (int i = 0; i < 4; i++) begin
            chk(tag, $sformatf("drv_en[%0d]", i), int'(bus_drv_en[i]), ex_en[i]);
            chk(tag, $sformatf("drv_val[%0d]", i), int'(bus_drv_val[i]), ex_val[i]);
        end
        @(posedge clk);
        ref_q = rst_n ? ex_x : 0;
        @(negedge clk);
    endtask

    task automatic rnd_data();
        nbr_a = 4'($urandom); nbr_b = 4'($urandom); bus_val = 4'($urandom);
    endtask

    task automatic quiet_bus();
        cfg_rd_src = 3'd0; cfg_wr_dst = 3'd0; cfg_turn_en = 2'd0; cfg_wr_dyn = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: register clear while reset is held.
        repeat (2) @(posedge clk);
        @(negedge clk);
        run("R8");
        rst_n = 1'b1;
        // R1: A operand sweep in pass state.
        cfg_state = 2'd0; quiet_bus(); cfg_b_gate = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 3; k++) begin
                cfg_a_src = 3'(s); rnd_data(); run("R1");
            end
        end
        // R2: B operand sweep with both gate values.
        for (int s = 0; s < 8; s++) begin
            for (int g = 0; g < 2; g++) begin
                cfg_b_src = 3'(s); cfg_b_gate = 1'(g); rnd_data(); run("R2");
            end
        end
        // R3: bus read sweep.
        cfg_a_src = 3'd4;
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 3; k++) begin
                cfg_rd_src = 3'(s); rnd_data(); run("R3");
            end
        end
        // R4..R7: each function state with random operands.
        for (int st = 0; st < 4; st++) begin
            cfg_state = 2'(st);
            for (int k = 0; k < 24; k++) begin
                quiet_bus();
                cfg_a_src = 3'($urandom); cfg_b_src = 3'($urandom);
                cfg_rd_src = 3'($urandom); cfg_b_gate = 1'($urandom); rnd_data();
                case (st)
                    0: run("R4");
                    1: run("R5");
                    2: run("R6");
                    default: run("R7");
                endcase
            end
        end
        // R8: asynchronous clear in the middle of a cycle.
        cfg_state = 2'd3; quiet_bus(); cfg_a_src = 3'd4; cfg_b_gate = 1'b0;
        run("R7");
        run("R7");
        rst_n = 1'b0;
        #1;
        chk("R8", "a_out mid-cycle", int'(a_out), 0);
        ref_q = 0;
        run("R8");
        rst_n = 1'b1;
        run("R8");
        // R9: writes, static and gated by B.
        for (int k = 0; k < 32; k++) begin
            quiet_bus(); cfg_state = 2'($urandom);
            cfg_a_src = 3'($urandom); cfg_b_src = 3'($urandom); cfg_b_gate = 1'($urandom);
            cfg_wr_dst = 3'(1 + (k % 4)); cfg_wr_dyn = 1'(k / 4 % 2); rnd_data();
            run("R9");
        end
        // R10: turns in both directions on both pairs.
        for (int k = 0; k < 16; k++) begin
            quiet_bus(); cfg_turn_en = 2'(k % 4); cfg_turn_dir = 2'(k / 4); rnd_data();
            run("R10");
        end
        // R11: forced collisions of read, write and turn.
        for (int k = 0; k < 24; k++) begin
            quiet_bus(); rnd_data(); cfg_state = 2'($urandom); cfg_b_gate = 1'($urandom);
            case (k % 3)
                0: begin cfg_rd_src = 3'(1 + (k % 4)); cfg_wr_dst = cfg_rd_src; end
                1: begin cfg_turn_en = 2'(1 + (k % 3)); cfg_wr_dst = 3'(1 + (k % 4)); end
                default: begin cfg_turn_en = 2'(1 + (k % 3)); cfg_rd_src = 3'(1 + (k % 4)); end
            endcase
            cfg_turn_dir = 2'($urandom);
            run("R11");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule